// File: doc/BRIEF.md
# Interlocked Bus Read Responder

This block answers reads on a shared bus that has no clock. The address and the returned word use the same set of lines. A requester places an address on the lines and raises its read request. The responder stores the address and acknowledges it. It then waits for the requester to withdraw the request and release the lines, and only after that drops its acknowledge. After a fixed internal access delay it drives the stored word onto the lines and raises its data-ready flag. The requester acknowledges the data. The responder then releases the lines and lowers data-ready. The exchange is over only when the requester withdraws that acknowledge.

Each step waits for an edge from the other party, so the protocol tolerates any delay between the two sides. The two incoming control lines are each brought into the local clock domain through a pair of flops. The block models the shared lines as separate incoming and outgoing buses plus a drive-enable. The word returned for an address is computed from a fixed pattern: word(a) = (a × 257 truncated to DW bits) XOR SEED, where a is the low AW bits of the lines. SEED defaults to 16'hA5C3.

Top module: `hs_read_resp`

## Requirements
- R1: While reset is low, and right after it is released, ack_out, rdy_out and bus_oe are all low.
- R2: When req_in goes high, the block stores the low AW bits of bus_in as the address and raises ack_out.
- R3: Once ack_out is high, it stays high while req_in stays high. It falls after req_in is seen low.
- R4: rdy_out rises no sooner than LAT clock cycles after ack_out rose. It never rises while ack_out is still high.
- R5: While rdy_out is high, bus_out is stable and equals word(a) for the stored address a.
- R6: bus_oe is high exactly when rdy_out is high. bus_oe is never high while ack_out is high.
- R7: rdy_out stays high until ack_in is seen high. Then rdy_out and bus_oe fall together.
- R8: After rdy_out falls, a high req_in is ignored (ack_out stays low) until ack_in has gone low. After that, the pending request is accepted.
- R9: req_in and ack_in each pass through two synchronizing flops. ack_out rises on the third rising clock edge after req_in rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 1 | Read request from the requester (asynchronous) |
| ack_in | input | 1 | Data acknowledge from the requester (asynchronous) |
| bus_in | input | DW | Value currently present on the shared lines |
| bus_out | output | DW | Word the responder drives onto the shared lines |
| bus_oe | output | 1 | Drive enable for bus_out |
| ack_out | output | 1 | Address acknowledge to the requester |
| rdy_out | output | 1 | Data-ready flag to the requester |

## Verification
The assertions assume the requester follows the interlock. It changes req_in only while ack_out is low, or in order to withdraw the request after seeing ack_out. It raises ack_in only after seeing rdy_out, and holds bus_in steady while req_in is high. The bench requester is written as that well-behaved party: every input change waits for the matching output edge. The one deliberate exception is a request raised early, before ack_in is withdrawn. The protocol allows this, and the bench uses it to show that the request is held off.

// File: rtl/hs_read_resp.sv
module hs_read_resp #(
  parameter int          DW   = 16,
  parameter int          AW   = 4,
  parameter int          LAT  = 3,
  parameter logic [15:0] SEED = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_in,
  input  logic          ack_in,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          ack_out,
  output logic          rdy_out
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1) + 1;

  typedef enum logic [4:0] {
    S_IDLE  = 5'b00001,
    S_ACK   = 5'b00010,
    S_WAIT  = 5'b00100,
    S_DRIVE = 5'b01000,
    S_DONE  = 5'b10000
  } st_t;

  st_t            st;
  logic           req_m, req_s, ack_m, ack_s;
  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  dout;
  logic [DW-1:0]  rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = DW'(g * 257) ^ DW'(SEED);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_m <= 1'b0; req_s <= 1'b0;
      ack_m <= 1'b0; ack_s <= 1'b0;
    end else begin
      req_m <= req_in; req_s <= req_m;
      ack_m <= ack_in; ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      cnt    <= '0;
      dout   <= '0;
    end else begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      unique case (st)
        S_IDLE:  if (req_s) begin
                   addr_q <= bus_in[AW-1:0];
                   cnt    <= '0;
                   st     <= S_ACK;
                 end
        S_ACK:   if (!req_s) st <= S_WAIT;
        S_WAIT:  if (cnt >= CW'(LAT)) begin
                   dout <= rom[addr_q];
                   st   <= S_DRIVE;
                 end
        S_DRIVE: if (ack_s) st <= S_DONE;
        S_DONE:  if (!ack_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ack_out = st[1];
  assign rdy_out = st[3];
  assign bus_oe  = st[3];
  assign bus_out = dout;

  logic       ack_d;
  logic [4:0] since_ack;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_d     <= 1'b0;
      since_ack <= '0;
    end else begin
      ack_d <= ack_out;
      if (ack_out && !ack_d) since_ack <= 5'd1;
      else if (since_ack != '1) since_ack <= since_ack + 1'b1;
    end
  end

  AST_ACK_HELD:     assert property (@(posedge clk) disable iff (!rst_n) ack_out && req_s |=> ack_out); // R3
  AST_RDY_LATE:     assert property (@(posedge clk) disable iff (!rst_n) $rose(rdy_out) |-> since_ack >= 5'(LAT) && !ack_out); // R4
  AST_DATA_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) rdy_out && $past(rdy_out) |-> $stable(bus_out)); // R5
  AST_NO_CLASH:     assert property (@(posedge clk) disable iff (!rst_n) !(bus_oe && ack_out)); // R6
  AST_RDY_HELD:     assert property (@(posedge clk) disable iff (!rst_n) rdy_out && !ack_s |=> rdy_out); // R7
  AST_NO_REACCEPT:  assert property (@(posedge clk) disable iff (!rst_n) st == S_DONE && ack_s |=> !ack_out); // R8
  AST_ONE_STATE:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(st)); // R6
endmodule

// File: tb/hs_read_resp_tb.sv
module hs_read_resp_tb_top;
  localparam int DW  = 16;
  localparam int AW  = 4;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_in = 1'b0;
  logic          ack_in = 1'b0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic          bus_oe, ack_out, rdy_out;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hs_read_resp #(.DW(DW), .AW(AW), .LAT(LAT), .SEED(16'hA5C3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ack_out(ack_out), .rdy_out(rdy_out)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    logic [DW-1:0] p;
    p = DW'(a) * DW'(257);
    return p ^ 16'hA5C3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_read(input logic [AW-1:0] a, input int hold);
    int n;
    int lat;
    bus_in = DW'(a);
    req_in = 1'b1;
    n = 0;
    while (!ack_out && n < 20) begin @(negedge clk); n++; end
    chk(ack_out, "R2 ack raised on request", ack_out, 1);
    chk(!rdy_out && !bus_oe, "R6 no drive while address ack", {rdy_out, bus_oe}, 0);
    lat = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); lat++;
      chk(ack_out, "R3 ack held while request high", ack_out, 1);
      chk(!bus_oe, "R6 no drive while requester drives", bus_oe, 0);
    end
    req_in = 1'b0;
    bus_in = '0;
    n = 0;
    while (ack_out && n < 10) begin @(negedge clk); n++; lat++; end
    chk(!ack_out, "R3 ack falls after request drop", ack_out, 0);
    while (!rdy_out && lat < 40) begin @(negedge clk); lat++; end
    chk(rdy_out && lat >= LAT, "R4 data-ready latency", lat, LAT);
    chk(!ack_out, "R4 ack low at data-ready", ack_out, 0);
    chk(bus_oe, "R6 drive enable with data-ready", bus_oe, 1);
    chk(bus_out == word_of(a), "R5 returned word", bus_out, word_of(a));
  endtask

  task automatic finish_read(input bit keep_ack);
    int n;
    logic [DW-1:0] held;
    held = bus_out;
    repeat (4) @(negedge clk);
    chk(rdy_out && bus_oe, "R7 data-ready held until ack", {rdy_out, bus_oe}, 2'b11);
    chk(bus_out == held, "R5 word stable", bus_out, held);
    ack_in = 1'b1;
    n = 0;
    while (rdy_out && n < 10) begin @(negedge clk); n++; end
    chk(!rdy_out && !bus_oe, "R7 release after ack", {rdy_out, bus_oe}, 0);
    if (!keep_ack) begin
      ack_in = 1'b0;
      repeat (5) @(negedge clk);
      chk(!ack_out && !rdy_out && !bus_oe, "R8 idle after exchange", {ack_out, rdy_out, bus_oe}, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!ack_out && !rdy_out && !bus_oe, "R1 outputs low in reset", {ack_out, rdy_out, bus_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_out && !rdy_out && !bus_oe, "R1 outputs low after reset", {ack_out, rdy_out, bus_oe}, 0);
  endtask

  task automatic t_sync_delay();
    bus_in = DW'(5);
    req_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!ack_out, "R9 ack low after two edges", ack_out, 0);
    @(negedge clk);
    chk(ack_out, "R9 ack high after third edge", ack_out, 1);
    start_read(4'd5, 0);
    finish_read(1'b0);
  endtask

  task automatic t_plain_reads();
    start_read(4'd0, 0);  finish_read(1'b0);
    start_read(4'd15, 1); finish_read(1'b0);
    start_read(4'd10, 8); finish_read(1'b0);
  endtask

  task automatic t_reaccept();
    start_read(4'd3, 0);
    finish_read(1'b1);
    bus_in = DW'(9);
    req_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!ack_out, "R8 request ignored while ack_in high", ack_out, 0);
    end
    ack_in = 1'b0;
    start_read(4'd9, 2);
    finish_read(1'b0);
  endtask

  initial begin
    t_reset();
    t_sync_delay();
    t_plain_reads();
    t_reaccept();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule